// File: doc/BRIEF.md
# Packed Pixel Unpacker

This block sits between a frame-buffer FIFO and the video output of a display controller. Each word it reads from the FIFO is 16 bits wide and holds several packed pixels. A run-time depth code selects 1, 2, 4 or 8 bits per pixel, so one word carries 16, 8, 4 or 2 pixels. On each pixel-clock enable during active display, the block emits the next pixel on an 8-bit output. The pixel is right-aligned and its upper bits are zero.

The FIFO read port is show-ahead: the word at its head is visible while the empty flag is low. The block uses that word in place. It raises the pop strobe in the same cycle as the enable that consumes the word's last pixel. While blanked, the output is held at zero and the position inside the word returns to the first pixel, so every line starts at bit 0 of the head word. If a word is needed while the FIFO is empty, the block shows black and sets a sticky underrun flag.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, `pix_out` is 0, `underrun` is 0 and `fifo_pop` is 0.
- R2: Depth code 2'b00 selects 1 bit per pixel, 2'b01 selects 2, 2'b10 selects 4 and 2'b11 selects 8. Pixel k of a word occupies bits [k*b + b-1 : k*b], where b is the pixel width, so pixel 0 is in the least significant bits. The pixel appears on `pix_out[b-1:0]` and the remaining upper bits are 0.
- R3: `fifo_pop` is high only in a cycle where `pix_en` is 1, `blank` is 0 and `fifo_empty` is 0, and the enable consumes the last pixel of the word (pixel 15, 7, 3 or 1 for depth codes 00, 01, 10 and 11). After a pop, the next pixel is taken from pixel 0 of the new head word.
- R4: In a cycle with `pix_en` low, `pix_out`, `underrun` and the position inside the word do not change, and `fifo_pop` stays 0.
- R5: An enable with `blank` high (active high) drives `pix_out` to 0, does not pop, and resets the position so that the next active pixel is pixel 0 of the head word.
- R6: An active enable while `fifo_empty` is high drives `pix_out` to 0, sets `underrun`, does not pop and does not advance the position. `underrun` then stays 1 until reset.
- R7: A pixel appears on `pix_out` one clock after the enable that selects it. Before that clock edge, `pix_out` still holds the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable |
| blank | input | 1 | Blanking, active high |
| depth | input | 2 | Bits-per-pixel code |
| fifo_empty | input | 1 | FIFO has no word at its head |
| fifo_data | input | 16 | Head word of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Consume the head word |
| pix_out | output | 8 | Right-aligned pixel, zero-padded |
| underrun | output | 1 | Sticky FIFO-starvation flag |

## Verification
Two events can coincide on one enable: consuming the last pixel of a word, which pops the FIFO, and either blanking or an empty FIFO, both of which must suppress that pop. The bench sweeps every depth code over many generated words, with idle cycles mixed in. It places blank and empty enables exactly on last-pixel positions as well as in the middle of words. After each one, it checks that the pop did not fire and that the next active pixel comes from the expected position: pixel 0 after a blank, and the same pixel retried after an empty FIFO. Expected pixels come from shifting and masking the word arithmetically in the bench.

// File: rtl/pixel_unpacker.sv
module pixel_unpacker #(
  parameter int WORD_W = 16,
  parameter int OUT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              blank,
  input  logic [1:0]        depth,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic [OUT_W-1:0]  pix_out,
  output logic              underrun
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int OFS_W = IDX_W + 3;

  logic [IDX_W-1:0] idx_q;

  wire [IDX_W-1:0] last_idx = IDX_W'((WORD_W >> depth) - 1);
  wire [OFS_W-1:0] bit_ofs  = {3'b000, idx_q} << depth;
  wire [5:0]       bpp      = 6'd1 << depth;
  wire [OUT_W-1:0] mask     = OUT_W'((64'd1 << bpp) - 64'd1);
  wire [WORD_W-1:0] shifted = fifo_data >> bit_ofs;
  wire [OUT_W-1:0] pixel    = shifted[OUT_W-1:0] & mask;
  wire             active   = pix_en & ~blank;
  wire             at_last  = (idx_q == last_idx);

  assign fifo_pop = active & ~fifo_empty & at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      pix_out  <= '0;
      underrun <= 1'b0;
    end else if (pix_en) begin
      if (blank) begin
        pix_out <= '0;
        idx_q   <= '0;
      end else if (fifo_empty) begin
        pix_out  <= '0;
        underrun <= 1'b1;
      end else begin
        pix_out <= pixel;
        idx_q   <= at_last ? '0 : idx_q + 1'b1;
      end
    end
  end
endmodule

module pixel_unpacker_chk #(
  parameter int WORD_W = 16,
  parameter int OUT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_en,
  input logic              blank,
  input logic [1:0]        depth,
  input logic              fifo_empty,
  input logic [WORD_W-1:0] fifo_data,
  input logic              fifo_pop,
  input logic [OUT_W-1:0]  pix_out,
  input logic              underrun
);
  // R3
  pop_gated_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (pix_en && !blank && !fifo_empty));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(pix_out) && $stable(underrun)));
  // R5
  blank_black_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && blank) |=> (pix_out == '0));
  // R6
  starve_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !blank && fifo_empty) |=> (underrun && pix_out == '0));
  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
  // R2
  one_bit_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && depth == 2'b00) |=> (pix_out[OUT_W-1:1] == '0));
  // R2
  two_bit_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && depth == 2'b01) |=> (pix_out[OUT_W-1:2] == '0));
  // R2
  four_bit_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && depth == 2'b10) |=> (pix_out[OUT_W-1:4] == '0));
endmodule

bind pixel_unpacker pixel_unpacker_chk #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/pixel_unpacker_bench.sv
module pixel_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_en = 1'b0;
  logic        blank = 1'b0;
  logic [1:0]  depth = 2'b00;
  logic        fifo_empty = 1'b1;
  logic [15:0] fifo_data = '0;
  logic        fifo_pop;
  logic [7:0]  pix_out;
  logic        underrun;

  pixel_unpacker u_pixel_unpacker (.*);

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int exp_idx = 0;
  int wcnt = 0;
  logic [7:0] exp_out = '0;
  logic exp_under = 1'b0;
  bit done = 1'b0;

  function automatic logic [15:0] gen_word(int n);
    logic [31:0] x;
    x = n * 32'h9E3779B1 + 32'h7F4A7C15;
    return x[31:16] ^ x[15:0];
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit en, bit bl, bit em);
    int bpp, ppw;
    bit exp_pop;
    @(negedge clk);
    pix_en = en; blank = bl; fifo_empty = em;
    #1;
    bpp = 1 << depth;
    ppw = 16 / bpp;
    exp_pop = en && !bl && !em && (exp_idx == ppw - 1);
    check("R3", "fifo_pop", fifo_pop, exp_pop);
    check("R7", "pix_out before edge", pix_out, exp_out);
    if (en) begin
      if (bl) begin
        exp_out = 0; exp_idx = 0;
      end else if (em) begin
        exp_out = 0; exp_under = 1'b1;
      end else begin
        exp_out = 8'((fifo_data >> (exp_idx * bpp)) & ((1 << bpp) - 1));
        exp_idx = exp_pop ? 0 : exp_idx + 1;
      end
    end
    @(posedge clk);
    #1;
    check(!en ? "R4" : bl ? "R5" : em ? "R6" : "R2", "pix_out", pix_out, exp_out);
    check(en && em && !bl ? "R6" : "R4", "underrun", underrun, exp_under);
    if (exp_pop) begin
      wcnt++;
      fifo_data = gen_word(wcnt);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "pix_out", pix_out, 0);
    check("R1", "underrun", underrun, 0);
    check("R1", "fifo_pop", fifo_pop, 0);
    fifo_data = gen_word(0);

    // R2 R3 R4: every depth, many words, idle cycles interleaved
    for (int d = 0; d < 4; d++) begin
      depth = 2'(d);
      for (int w = 0; w < 12; w++)
        for (int p = 0; p < (16 >> d); p++) begin
          if ((p + w) % 3 == 0) step(1'b0, 1'b0, 1'b0);
          step(1'b1, 1'b0, 1'b0);
        end
    end

    // single-bit walking words at 1 bpp and 8 bpp
    for (int d = 0; d < 4; d += 3) begin
      depth = 2'(d);
      for (int k = 0; k < 16; k++) begin
        fifo_data = 16'h1 << k;
        for (int p = 0; p < (16 >> d); p++) step(1'b1, 1'b0, 1'b0);
      end
    end

    // R5: blank mid-word and on the last pixel, then restart at pixel 0
    for (int d = 0; d < 4; d++) begin
      depth = 2'(d);
      step(1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      for (int p = 0; p < (16 >> d) - 1; p++) step(1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      for (int p = 0; p < (16 >> d); p++) step(1'b1, 1'b0, 1'b0);
    end

    // R6: starve mid-word and on the last pixel; flag stays set
    depth = 2'b10;
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    for (int d = 0; d < 4; d++) begin
      depth = 2'(d);
      for (int p = 0; p < 20; p++) step(1'b1, 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule